// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register Bank

This block is the host-facing register bank for 48 open-drain digital lines. A simple synchronous strobe interface reaches it: a 4-bit byte address, 8-bit write and read buses, and a write strobe and a read strobe. The six port registers hold one pull-down control bit per line. Writing 1 to a bit turns on the pull-down for that line. Writing 0 releases the pad, and an external resistor then pulls it high. A port read returns the inverted pad level, so each line reads as 1 when it is low.

The pad inputs go through a two-flop synchronizer. The synchronized levels are also handed out to a separate edge-detection block. That block returns per-line event strobes for the first 24 lines. Those strobes set interrupt-flag bits, but only on lines whose enable bit is set.

Three byte addresses are shared by three banks: polarity, enable and interrupt flag. A 2-bit page field in the page/lock register chooses the bank. That register also carries one write-lock bit per port. A status byte collects one pending bit for each flag byte. Read data is registered and appears on the cycle after the read strobe.

Top module: `oc_gpio_bank`

## Requirements
- R1: After reset, every pull-down output, every polarity, enable and flag bit, the page field, the lock bits and the read data are zero.
- R2: A write to port offset p (0x0 to 0x5) sets pull-down outputs [8p+7:8p] to the write data on the next cycle. Bit value 1 drives the line low and 0 releases it.
- R3: A read of port offset p returns the bitwise inverse of the synchronized pad levels of lines [8p+7:8p]. The read data appears on the cycle after the read strobe and holds while no read strobe is given.
- R4: Offset 0x7 is the page/lock register. The page is in bits 7:6 and the lock bit for port p is in bit p (bits 5:0). It reads back as written.
- R5: Offsets 0x8, 0x9 and 0xA access byte k = offset-8, which covers lines [8k+7:8k]. Page 1 selects polarity, page 2 selects enable and page 3 selects the flag byte. Polarity and enable are presented on their outputs.
- R6: While page 0 is selected, reads of 0x8 to 0xA return 0x00 and writes there change nothing.
- R7: While lock bit p is set, writes to port p are ignored. Reads of port p still return the inverted pad level.
- R8: Offset 0x6 reads the pending status: bit k is the OR of flag byte k and bits 7:3 are zero. The irq output is the OR of all flag bits.
- R9: An event strobe on line i (i < 24) sets flag bit i only if enable bit i is set. A host write to a flag byte replaces it, and an enabled event strobe in the same cycle still sets its bit.
- R10: The port registers are reachable whatever page is selected.
- R11: Offsets 0xB to 0xF read 0x00 and writes to them have no effect.
- R12: The synchronized pad output equals the raw pad input delayed by two clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 48 | Raw pad levels |
| pad_pulldn_o | output | 48 | Pull-down enable per line (1 = drive low) |
| pad_sync_o | output | 48 | Synchronized pad levels for the edge logic |
| evt_set_i | input | 24 | Per-line event strobes from the edge logic |
| evt_pol_o | output | 24 | Polarity bits for the edge logic |
| evt_ena_o | output | 24 | Enable bits for the edge logic |
| irq_o | output | 1 | Any flag bit set |

## Verification
The assertions assume that the reset deassertion is already aligned to the clock. They also assume that strobes, address and data change only away from the rising edge, and that a read and a write issued in the same cycle see the state from before that write. The bench drives every input on the falling edge and issues at most one strobe per cycle. It models each pad as low when either the block's pull-down or an external driver pulls it low, so the pad-level checks follow only the requirements. Event strobes last one cycle, and the host write to the flag byte is lined up with a strobe only in the case that checks which of the two wins.

// File: rtl/oc_gpio_pkg.sv
package oc_gpio_pkg;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_FLAG = 2'd3
  } page_e;

endpackage

// File: rtl/oc_gpio_sync.sv
module oc_gpio_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/oc_gpio_port.sv
module oc_gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;
  logic         latch_en;

  always_comb begin
    latch_en = we_i && !lock_i;
    latch_d  = latch_en ? wdata_i : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  assign q_o = latch_q;

endmodule

// File: rtl/oc_gpio_paged.sv
module oc_gpio_paged
  import oc_gpio_pkg::*;
#(
  parameter int W     = 8,
  parameter int BYTES = 3,
  localparam int N    = W * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTES-1:0] wsel_i,
  input  page_e            page_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [N-1:0]     set_i,
  output logic [N-1:0]     pol_o,
  output logic [N-1:0]     ena_o,
  output logic [N-1:0]     flag_o
);

  for (genvar b = 0; b < BYTES; b++) begin : gen_byte
    logic [W-1:0] pol_q, pol_d;
    logic [W-1:0] ena_q, ena_d;
    logic [W-1:0] flg_q, flg_d;
    logic [W-1:0] hit;

    always_comb begin
      hit   = set_i[b*W +: W] & ena_q;
      pol_d = pol_q;
      ena_d = ena_q;
      flg_d = flg_q;
      if (wsel_i[b] && page_i == PG_POL) pol_d = wdata_i;
      if (wsel_i[b] && page_i == PG_ENA) ena_d = wdata_i;
      if (wsel_i[b] && page_i == PG_FLAG) flg_d = wdata_i;
      flg_d = flg_d | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q <= '0;
        ena_q <= '0;
        flg_q <= '0;
      end else begin
        pol_q <= pol_d;
        ena_q <= ena_d;
        flg_q <= flg_d;
      end
    end

    assign pol_o[b*W +: W]  = pol_q;
    assign ena_o[b*W +: W]  = ena_q;
    assign flag_o[b*W +: W] = flg_q;
  end

endmodule

// File: rtl/oc_gpio_bank.sv
module oc_gpio_bank
  import oc_gpio_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int EVT_BYTES = 3,
  parameter int ADR_W     = 4,
  localparam int LINES     = PORT_W * NUM_PORTS,
  localparam int EVT_LINES = PORT_W * EVT_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADR_W-1:0]     addr_i,
  input  logic [PORT_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [PORT_W-1:0]    rdata_o,
  input  logic [LINES-1:0]     pad_in_i,
  output logic [LINES-1:0]     pad_pulldn_o,
  output logic [LINES-1:0]     pad_sync_o,
  input  logic [EVT_LINES-1:0] evt_set_i,
  output logic [EVT_LINES-1:0] evt_pol_o,
  output logic [EVT_LINES-1:0] evt_ena_o,
  output logic                 irq_o
);

  localparam int ADR_PEND  = NUM_PORTS;
  localparam int ADR_PGLK  = NUM_PORTS + 1;
  localparam int ADR_PAGED = NUM_PORTS + 2;

  logic [NUM_PORTS-1:0] port_we;
  logic [EVT_BYTES-1:0] paged_we;
  logic                 pglk_we;
  page_e                page_q, page_d;
  logic [NUM_PORTS-1:0] lock_q, lock_d;
  logic [EVT_LINES-1:0] flag;
  logic [PORT_W-1:0]    rd_d;
  logic [PORT_W-1:0]    rdata_q, rdata_d;

  // Address decode of write strobes
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      port_we[p] = wr_i && (addr_i == ADR_W'(p));
    end
    for (int b = 0; b < EVT_BYTES; b++) begin
      paged_we[b] = wr_i && (addr_i == ADR_W'(ADR_PAGED + b));
    end
    pglk_we = wr_i && (addr_i == ADR_W'(ADR_PGLK));
  end

  // Page / lock register
  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (pglk_we) begin
      page_d = page_e'(wdata_i[PORT_W-1 -: 2]);
      lock_d = wdata_i[NUM_PORTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (pglk_we) begin
      page_q <= page_d;
      lock_q <= lock_d;
    end
  end

  // Pad synchronizer
  oc_gpio_sync #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_in_i),
    .q_o   (pad_sync_o)
  );

  // Port latches
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gen_port
    oc_gpio_port #(.W(PORT_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (port_we[p]),
      .lock_i  (lock_q[p]),
      .wdata_i (wdata_i),
      .q_o     (pad_pulldn_o[p*PORT_W +: PORT_W])
    );
  end

  // Paged polarity / enable / flag banks
  oc_gpio_paged #(.W(PORT_W), .BYTES(EVT_BYTES)) u_paged (
    .clk     (clk),
    .rst_n   (rst_n),
    .wsel_i  (paged_we),
    .page_i  (page_q),
    .wdata_i (wdata_i),
    .set_i   (evt_set_i),
    .pol_o   (evt_pol_o),
    .ena_o   (evt_ena_o),
    .flag_o  (flag)
  );

  // Read mux
  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == ADR_W'(p)) rd_d = ~pad_sync_o[p*PORT_W +: PORT_W];
    end
    if (addr_i == ADR_W'(ADR_PEND)) begin
      for (int b = 0; b < EVT_BYTES; b++) begin
        rd_d[b] = |flag[b*PORT_W +: PORT_W];
      end
    end
    if (addr_i == ADR_W'(ADR_PGLK)) rd_d = PORT_W'({page_q, lock_q});
    for (int b = 0; b < EVT_BYTES; b++) begin
      if (addr_i == ADR_W'(ADR_PAGED + b)) begin
        unique case (page_q)
          PG_POL:  rd_d = evt_pol_o[b*PORT_W +: PORT_W];
          PG_ENA:  rd_d = evt_ena_o[b*PORT_W +: PORT_W];
          PG_FLAG: rd_d = flag[b*PORT_W +: PORT_W];
          default: rd_d = '0;
        endcase
      end
    end
  end

  always_comb rdata_d = rd_i ? rd_d : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |flag;

endmodule

// File: rtl/oc_gpio_bank_chk.sv
module oc_gpio_bank_chk #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int ADR_W     = 4,
  localparam int LINES    = PORT_W * NUM_PORTS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADR_W-1:0]     addr_i,
  input logic [PORT_W-1:0]    wdata_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [PORT_W-1:0]    rdata_o,
  input logic [LINES-1:0]     pad_in_i,
  input logic [LINES-1:0]     pad_sync_o,
  input logic [LINES-1:0]     pad_pulldn_o,
  input logic                 irq_o,
  input logic [NUM_PORTS-1:0] lock_q,
  input logic [1:0]           page_q
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  // R2
  a_r2_pulldn_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADR_W'(0) && !lock_q[0]) |=> pad_pulldn_o[PORT_W-1:0] == $past(wdata_i));

  // R7
  a_r7_locked_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADR_W'(1) && lock_q[1]) |=> $stable(pad_pulldn_o[2*PORT_W-1:PORT_W]));

  // R6
  a_r6_page0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADR_W'(NUM_PORTS + 2) && page_q == 2'd0) |=> rdata_o == '0);

  // R8
  a_r8_pending_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADR_W'(NUM_PORTS)) |=> ((rdata_o != '0) == $past(irq_o)) && (rdata_o[PORT_W-1:3] == '0));

  // R11
  a_r11_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i > ADR_W'(NUM_PORTS + 4)) |=> rdata_o == '0);

  // R12
  a_r12_sync_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> pad_sync_o == $past(pad_in_i, 2));

endmodule

bind oc_gpio_bank oc_gpio_bank_chk #(
  .PORT_W    (PORT_W),
  .NUM_PORTS (NUM_PORTS),
  .ADR_W     (ADR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .pad_in_i     (pad_in_i),
  .pad_sync_o   (pad_sync_o),
  .pad_pulldn_o (pad_pulldn_o),
  .irq_o        (irq_o),
  .lock_q       (lock_q),
  .page_q       (page_q)
);

// File: tb/oc_gpio_bank_bench.sv
`timescale 1ns/1ps
module oc_gpio_bank_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic        wr;
  logic        rd;
  logic [7:0]  rdata;
  logic [47:0] pad_in;
  logic [47:0] pulldn;
  logic [47:0] pad_sync;
  logic [23:0] evt_set;
  logic [23:0] pol;
  logic [23:0] ena;
  logic        irq;
  logic [47:0] ext_low;

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pad is low when either side pulls it down, otherwise the resistor pulls it high
  assign pad_in = ~(pulldn | ext_low);

  oc_gpio_bank u_oc_gpio_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .wr_i         (wr),
    .rd_i         (rd),
    .rdata_o      (rdata),
    .pad_in_i     (pad_in),
    .pad_pulldn_o (pulldn),
    .pad_sync_o   (pad_sync),
    .evt_set_i    (evt_set),
    .evt_pol_o    (pol),
    .evt_ena_o    (ena),
    .irq_o        (irq)
  );

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pulldn", pulldn, 48'h0);
    check("R1 rdata", {40'h0, rdata}, 48'h0);
    check("R1 pol", {24'h0, pol}, 48'h0);
    check("R1 ena", {24'h0, ena}, 48'h0);
    check("R1 irq", {47'h0, irq}, 48'h0);
    rd_reg(4'h7, v); check("R1 page/lock", {40'h0, v}, 48'h0);
    rd_reg(4'h0, v); check("R1 port0 released", {40'h0, v}, 48'h0);
    wr_reg(4'h7, 8'hC0);
    rd_reg(4'h8, v); check("R1 flag byte0", {40'h0, v}, 48'h0);
    wr_reg(4'h7, 8'h00);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr_reg(4'h0, 8'hA5);
    check("R2 port0 pulldn", {40'h0, pulldn[7:0]}, 48'hA5);
    wr_reg(4'h5, 8'h3C);
    check("R2 port5 pulldn", {40'h0, pulldn[47:40]}, 48'h3C);
    settle();
    rd_reg(4'h0, v); check("R3 port0 readback inverted", {40'h0, v}, 48'hA5);
    repeat (2) @(negedge clk);
    check("R3 rdata holds", {40'h0, rdata}, 48'hA5);
    wr_reg(4'h0, 8'h00);
    check("R2 port0 released", {40'h0, pulldn[7:0]}, 48'h0);
    wr_reg(4'h5, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] v;
    @(negedge clk);
    ext_low[23:16] = 8'h81;
    @(negedge clk);
    check("R12 sync after 1 cycle", {40'h0, pad_sync[23:16]}, 48'hFF);
    @(negedge clk);
    check("R12 sync after 2 cycles", {40'h0, pad_sync[23:16]}, 48'h7E);
    rd_reg(4'h2, v); check("R3 port2 external low", {40'h0, v}, 48'h81);
    ext_low = '0;
    settle();
    rd_reg(4'h2, v); check("R3 port2 released", {40'h0, v}, 48'h0);
  endtask

  task automatic t_pglk();
    logic [7:0] v;
    wr_reg(4'h7, 8'h80);
    rd_reg(4'h7, v); check("R4 page/lock readback", {40'h0, v}, 48'h80);
    wr_reg(4'h7, 8'h00);
  endtask

  task automatic t_paged();
    logic [7:0] v;
    wr_reg(4'h7, 8'h40);
    wr_reg(4'h8, 8'h11); wr_reg(4'h9, 8'h22); wr_reg(4'hA, 8'h33);
    wr_reg(4'h7, 8'h80);
    wr_reg(4'h8, 8'hF0); wr_reg(4'h9, 8'h0F); wr_reg(4'hA, 8'h5A);
    check("R5 polarity out", {24'h0, pol}, 48'h332211);
    check("R5 enable out", {24'h0, ena}, 48'h5A0FF0);
    rd_reg(4'h9, v); check("R5 enable byte1", {40'h0, v}, 48'h0F);
    wr_reg(4'h7, 8'h40);
    rd_reg(4'hA, v); check("R5 polarity byte2", {40'h0, v}, 48'h33);
  endtask

  task automatic t_page0();
    logic [7:0] v;
    wr_reg(4'h7, 8'h00);
    wr_reg(4'h8, 8'hFF);
    wr_reg(4'hA, 8'hFF);
    rd_reg(4'h8, v); check("R6 page0 read", {40'h0, v}, 48'h0);
    check("R6 polarity untouched", {24'h0, pol}, 48'h332211);
    check("R6 enable untouched", {24'h0, ena}, 48'h5A0FF0);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    wr_reg(4'h1, 8'h0F);
    wr_reg(4'h7, 8'h02);
    wr_reg(4'h1, 8'hF0);
    check("R7 locked port1 unchanged", {40'h0, pulldn[15:8]}, 48'h0F);
    wr_reg(4'h0, 8'h77);
    check("R7 unlocked port0 writes", {40'h0, pulldn[7:0]}, 48'h77);
    settle();
    rd_reg(4'h1, v); check("R7 locked port1 still reads", {40'h0, v}, 48'h0F);
    wr_reg(4'h7, 8'h00);
    wr_reg(4'h1, 8'hF0);
    check("R7 after unlock", {40'h0, pulldn[15:8]}, 48'hF0);
    wr_reg(4'h1, 8'h00); wr_reg(4'h0, 8'h00);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    wr_reg(4'h7, 8'h80);
    wr_reg(4'h8, 8'h0F); wr_reg(4'h9, 8'hFF); wr_reg(4'hA, 8'h00);
    @(negedge clk);
    evt_set = 24'h0000FF;
    @(negedge clk);
    evt_set = '0;
    check("R9 only enabled bits flagged / R8 irq", {47'h0, irq}, 48'h1);
    rd_reg(4'h6, v); check("R8 pending byte0", {40'h0, v}, 48'h01);
    wr_reg(4'h7, 8'hC0);
    rd_reg(4'h8, v); check("R9 flag byte0", {40'h0, v}, 48'h0F);
    wr_reg(4'h8, 8'h00);
    check("R8 irq cleared", {47'h0, irq}, 48'h0);
    rd_reg(4'h6, v); check("R8 pending clear", {40'h0, v}, 48'h0);
    // host clears byte1 while an enabled event strobe arrives
    @(negedge clk);
    addr = 4'h9; wdata = 8'h00; wr = 1'b1; evt_set = 24'h000100;
    @(negedge clk);
    wr = 1'b0; evt_set = '0;
    rd_reg(4'h9, v); check("R9 set wins over clear", {40'h0, v}, 48'h01);
    rd_reg(4'h6, v); check("R8 pending byte1", {40'h0, v}, 48'h02);
    @(negedge clk);
    evt_set = 24'hFF0000;
    @(negedge clk);
    evt_set = '0;
    rd_reg(4'hA, v); check("R9 disabled byte2 not flagged", {40'h0, v}, 48'h0);
    wr_reg(4'h9, 8'h00);
  endtask

  task automatic t_page_indep();
    logic [7:0] v;
    wr_reg(4'h7, 8'hC0);
    wr_reg(4'h3, 8'h55);
    check("R10 port3 under page3", {40'h0, pulldn[31:24]}, 48'h55);
    settle();
    rd_reg(4'h3, v); check("R10 port3 read under page3", {40'h0, v}, 48'h55);
    wr_reg(4'h3, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    logic [47:0] pd;
    wr_reg(4'h7, 8'h40);
    wr_reg(4'h4, 8'h99);
    pd = pulldn;
    for (int a = 11; a < 16; a++) wr_reg(4'(a), 8'hFF);
    check("R11 pulldn untouched", pulldn, pd);
    check("R11 polarity untouched", {24'h0, pol}, 48'h332211);
    rd_reg(4'h7, v); check("R11 page/lock untouched", {40'h0, v}, 48'h40);
    for (int a = 11; a < 16; a++) begin
      rd_reg(4'(a), v); check("R11 unused read", {40'h0, v}, 48'h0);
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    evt_set = '0; ext_low = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_input();
    t_pglk();
    t_paged();
    t_page0();
    t_lock();
    t_flags();
    t_page_indep();
    t_unused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule